// File: doc/BRIEF.md
# Edge-Qualified Status Interrupt Controller

This block turns level changes on five asynchronous status lines into sticky interrupt events. The lines are host disconnect, VBUS valid, session valid, session end and ID ground. Every line is brought into the clock domain by a two-stage synchronizer and compared with its value one cycle earlier. A low-to-high change raises an event only if that line's bit in the rising-enable register is set. A high-to-low change raises an event only if its bit in the falling-enable register is set. Events set bits in a pending vector. The interrupt output is high while any pending bit is set. Software clears pending bits with a write-one-to-clear strobe.

Two lines are qualified further. Host-disconnect changes count only in host mode, where both the D+ and D- pull-down controls are high. ID-ground changes are ignored until the ID pull-up control has stayed high for a settle time, given as a number of cycles. The counter for that time starts again whenever the pull-up drops. Receive-active and receive-error indications do not pass through the enables. They drive an urgent output directly, in the same cycle.

Each enable register has three write addresses: one loads it, one ORs in ones, and one clears the bits written as one. Reads are combinational, and any of the three addresses returns the register contents.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, both enable registers read 0x1F (bits 4:0 set, bits 7:5 zero), `evt_pending` is 0 and `irq` is 0.
- R2: The rising-enable register reads at 0x0D, 0x0E and 0x0F. A write to 0x0D loads all 8 bits. A write to 0x0E ORs the write data in. A write to 0x0F clears the bits where the write data is 1.
- R3: The falling-enable register behaves in the same way at 0x10 (load), 0x11 (set) and 0x12 (clear), and all three addresses read it.
- R4: A read of any other address returns 0. A write to any other address changes neither enable register.
- R5: Status bit mapping: bit 0 host disconnect, 1 VBUS valid, 2 session valid, 3 session end, 4 ID ground. A 0-to-1 change of `stat_in[i]` with rising-enable bit i set, or a 1-to-0 change with falling-enable bit i set, sets `evt_pending[i]`. The bit is visible after the third rising clock edge that follows the change.
- R6: A change whose edge-enable bit is clear sets no pending bit. This includes an input whose rising and falling enables are both clear.
- R7: A change on bit 0 sets a pending bit only while both `pulldn_dp` and `pulldn_dm` are 1.
- R8: A change on bit 4 sets a pending bit only after `id_pullup` has been sampled high for SETTLE_CYCLES consecutive clock edges. Dropping `id_pullup` restarts that count.
- R9: Pending bits are sticky. A cycle with `clr_valid` high clears the bits where `clr_mask` is 1. An event that arrives in the same cycle as its clear leaves the bit set.
- R10: `irq` is 1 exactly when at least one `evt_pending` bit is 1.
- R11: `rx_urgent` equals `rx_active | rx_error` in the same cycle, regardless of the enable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| stat_in | input | 5 | Asynchronous status lines |
| pulldn_dp | input | 1 | D+ pull-down control |
| pulldn_dm | input | 1 | D- pull-down control |
| id_pullup | input | 1 | ID pull-up control |
| clr_valid | input | 1 | Write-one-to-clear strobe for pending bits |
| clr_mask | input | 5 | Pending bits to clear |
| rx_active | input | 1 | Receive-active indication |
| rx_error | input | 1 | Receive-error indication |
| evt_pending | output | 5 | Sticky event bits |
| irq | output | 1 | Interrupt, OR of pending bits |
| rx_urgent | output | 1 | Immediate receive notification |

## Verification
The assertions assume that `pulldn_dp`, `pulldn_dm` and `id_pullup` are synchronous to `clk`, and that a status line, once changed, stays at its new level long enough to pass both synchronizer stages. The stimulus meets both conditions. It drives every input on the falling clock edge and waits at least four cycles between status changes. It also holds the host-mode and pull-up controls steady through each detection window, so each event is attributed to one known qualifier state.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int SRC_N  = 5;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 8;

  localparam logic [REG_W-1:0] EN_RESET = 8'h1F;

  localparam logic [ADDR_W-1:0] RISE_BASE = 8'h0D;
  localparam logic [ADDR_W-1:0] FALL_BASE = 8'h10;

  localparam int SRC_HOSTDISC = 0;
  localparam int SRC_VBUS     = 1;
  localparam int SRC_SESSVLD  = 2;
  localparam int SRC_SESSEND  = 3;
  localparam int SRC_IDGND    = 4;

  typedef enum logic [1:0] {
    WOP_NONE = 2'd0,
    WOP_LOAD = 2'd1,
    WOP_SET  = 2'd2,
    WOP_CLR  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/eirq_en_reg.sv
module eirq_en_reg
  import eirq_pkg::*;
#(
  parameter int                AW      = ADDR_W,
  parameter int                DW      = REG_W,
  parameter logic [AW-1:0]     BASE    = RISE_BASE,
  parameter logic [DW-1:0]     RST_VAL = EN_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] value
);
  // offset from base: 0 load, 1 set, 2 clear
  logic [AW-1:0] offs;
  wr_op_e        op;
  logic [DW-1:0] nxt;

  assign offs = addr - BASE;
  assign hit  = (addr >= BASE) && (offs < AW'(3));

  always_comb begin
    op = WOP_NONE;
    if (wr && hit) begin
      unique case (offs[1:0])
        2'd0:    op = WOP_LOAD;
        2'd1:    op = WOP_SET;
        default: op = WOP_CLR;
      endcase
    end
  end

  always_comb begin
    unique case (op)
      WOP_LOAD: nxt = wdata;
      WOP_SET:  nxt = value | wdata;
      WOP_CLR:  nxt = value & ~wdata;
      default:  nxt = value;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= RST_VAL;
    else        value <= nxt;
  end
endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= async_in[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise[g] = sync_q & ~prev_q;
      assign fall[g] = ~sync_q & prev_q;
    end
  endgenerate
endmodule

// File: rtl/eirq_settle.sv
module eirq_settle #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic settled
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!enable)    cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign settled = (cnt_q == LIMIT);
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_valid,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pending,
  output logic         irq
);
  logic [W-1:0] clr_bits;
  assign clr_bits = clr_valid ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~clr_bits) | evt;
  end

  assign irq = |pending;
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [SRC_N-1:0]  stat_in,
  input  logic              pulldn_dp,
  input  logic              pulldn_dm,
  input  logic              id_pullup,
  input  logic              clr_valid,
  input  logic [SRC_N-1:0]  clr_mask,
  input  logic              rx_active,
  input  logic              rx_error,
  output logic [SRC_N-1:0]  evt_pending,
  output logic              irq,
  output logic              rx_urgent
);
  logic [REG_W-1:0] en_rise, en_fall;
  logic             hit_rise, hit_fall;
  logic [SRC_N-1:0] rise, fall, qual, evt;
  logic             id_settled;

  eirq_en_reg #(.AW(ADDR_W), .DW(REG_W), .BASE(RISE_BASE), .RST_VAL(EN_RESET)) u_rise (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit_rise), .value(en_rise)
  );

  eirq_en_reg #(.AW(ADDR_W), .DW(REG_W), .BASE(FALL_BASE), .RST_VAL(EN_RESET)) u_fall (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit_fall), .value(en_fall)
  );

  always_comb begin
    if (hit_rise)      reg_rdata = en_rise;
    else if (hit_fall) reg_rdata = en_fall;
    else               reg_rdata = '0;
  end

  eirq_edge_det #(.W(SRC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_in(stat_in), .rise(rise), .fall(fall)
  );

  eirq_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .enable(id_pullup), .settled(id_settled)
  );

  always_comb begin
    qual               = '1;
    qual[SRC_HOSTDISC] = pulldn_dp & pulldn_dm;
    qual[SRC_IDGND]    = id_settled;
  end

  assign evt = ((rise & en_rise[SRC_N-1:0]) | (fall & en_fall[SRC_N-1:0])) & qual;

  eirq_latch #(.W(SRC_N)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .pending(evt_pending), .irq(irq)
  );

  assign rx_urgent = rx_active | rx_error;
endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk #(
  parameter int SETTLE_CYCLES = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       pulldn_dp,
  input logic       pulldn_dm,
  input logic       id_pullup,
  input logic       clr_valid,
  input logic [4:0] clr_mask,
  input logic [4:0] evt_pending,
  input logic [7:0] en_rise,
  input logic [7:0] en_fall
);
  localparam int HW = $clog2(SETTLE_CYCLES + 1) + 1;
  logic [HW-1:0] hi_cnt;
  logic          mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              hi_cnt <= '0;
    else if (!id_pullup)                     hi_cnt <= '0;
    else if (hi_cnt < HW'(SETTLE_CYCLES))    hi_cnt <= hi_cnt + 1'b1;
  end

  assign mapped = (reg_addr >= 8'h0D) && (reg_addr <= 8'h12);

  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_rise == 8'h1F && en_fall == 8'h1F && evt_pending == 5'd0));

  assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h0E) |=> en_rise == ($past(en_rise) | $past(reg_wdata)));

  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h12) |=> en_fall == ($past(en_fall) & ~$past(reg_wdata)));

  assert_unmapped_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == 8'h00);

  assert_unmapped_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mapped) |=> (en_rise == $past(en_rise) && en_fall == $past(en_fall)));

  assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_pending & ~$past(evt_pending) & ~($past(en_rise[4:0]) | $past(en_fall[4:0]))) == 5'd0));

  assert_host_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_pending[0]) |-> $past(pulldn_dp && pulldn_dm));

  assert_id_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_pending[4]) |-> $past(hi_cnt >= HW'(SETTLE_CYCLES)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_pending) & ~($past(clr_valid) ? $past(clr_mask) : 5'd0) & ~evt_pending) == 5'd0));
endmodule

bind eirq_ctrl eirq_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .pulldn_dp(pulldn_dp), .pulldn_dm(pulldn_dm), .id_pullup(id_pullup),
  .clr_valid(clr_valid), .clr_mask(clr_mask), .evt_pending(evt_pending),
  .en_rise(en_rise), .en_fall(en_fall)
);

// File: tb/sim_eirq_ctrl.sv
module sim_eirq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [4:0] stat_in;
  logic       pulldn_dp, pulldn_dm, id_pullup;
  logic       clr_valid;
  logic [4:0] clr_mask;
  logic       rx_active, rx_error;
  logic [4:0] evt_pending;
  logic       irq, rx_urgent;

  int errs = 0;
  int checks = 0;
  logic done = 1'b0;

  logic [7:0] m_rise, m_fall;
  logic [4:0] m_pend;
  logic       id_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  eirq_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .stat_in(stat_in), .pulldn_dp(pulldn_dp), .pulldn_dm(pulldn_dm),
    .id_pullup(id_pullup), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .rx_active(rx_active), .rx_error(rx_error), .evt_pending(evt_pending),
    .irq(irq), .rx_urgent(rx_urgent)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] apply_op(input logic [7:0] cur, input int off, input logic [7:0] d);
    if (off == 0) return d;
    if (off == 1) return cur | d;
    return cur & ~d;
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h0D && a <= 8'h0F) m_rise = apply_op(m_rise, int'(a - 8'h0D), d);
    else if (a >= 8'h10 && a <= 8'h12) m_fall = apply_op(m_fall, int'(a - 8'h10), d);
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a >= 8'h0D && a <= 8'h0F) return m_rise;
    if (a >= 8'h10 && a <= 8'h12) return m_fall;
    return 8'h00;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    reg_addr = a;
    #1;
    chk(req, {24'd0, reg_rdata}, {24'd0, model_rd(a)});
  endtask

  task automatic stat_change(input string req, input logic [4:0] nv);
    logic [4:0] old, r, f, q;
    old = stat_in;
    stat_in = nv;
    repeat (3) @(negedge clk);
    r = nv & ~old;
    f = old & ~nv;
    q = {id_ok, 3'b111, pulldn_dp & pulldn_dm};
    m_pend = m_pend | (((r & m_rise[4:0]) | (f & m_fall[4:0])) & q);
    chk(req, {27'd0, evt_pending}, {27'd0, m_pend});
    chk("R10", {31'd0, irq}, {31'd0, |m_pend});
    @(negedge clk);
  endtask

  task automatic do_clr(input logic [4:0] mask);
    clr_valid = 1'b1; clr_mask = mask;
    @(negedge clk);
    clr_valid = 1'b0;
    m_pend = m_pend & ~mask;
    chk("R9 clear", {27'd0, evt_pending}, {27'd0, m_pend});
    chk("R10", {31'd0, irq}, {31'd0, |m_pend});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    stat_in = 5'd0; pulldn_dp = 1'b1; pulldn_dm = 1'b1; id_pullup = 1'b1;
    clr_valid = 1'b0; clr_mask = 5'd0; rx_active = 1'b0; rx_error = 1'b0;
    m_rise = 8'h1F; m_fall = 8'h1F; m_pend = 5'd0; id_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 rise reset", 8'h0D);
    rd_chk("R1 fall reset", 8'h10);
    chk("R1 pending", {27'd0, evt_pending}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 rising register aliases
    bus_wr(8'h0D, 8'h05); rd_chk("R2 load", 8'h0D); rd_chk("R2 alias", 8'h0E); rd_chk("R2 alias", 8'h0F);
    bus_wr(8'h0E, 8'hB2); rd_chk("R2 set", 8'h0D);
    bus_wr(8'h0F, 8'h83); rd_chk("R2 clear", 8'h0F);
    bus_wr(8'h0D, 8'h1F); rd_chk("R2 restore", 8'h0E);

    // R3 falling register aliases
    bus_wr(8'h10, 8'h0A); rd_chk("R3 load", 8'h11); rd_chk("R3 alias", 8'h12);
    bus_wr(8'h11, 8'h61); rd_chk("R3 set", 8'h10);
    bus_wr(8'h12, 8'h4B); rd_chk("R3 clear", 8'h10);
    bus_wr(8'h10, 8'h1F); rd_chk("R3 restore", 8'h12);

    // R4 unmapped
    rd_chk("R4 read 0x0C", 8'h0C); rd_chk("R4 read 0x13", 8'h13); rd_chk("R4 read 0xFF", 8'hFF);
    bus_wr(8'h13, 8'hFF); bus_wr(8'h0C, 8'h00);
    rd_chk("R4 write ignored rise", 8'h0D); rd_chk("R4 write ignored fall", 8'h10);

    // R11 urgent path
    for (int i = 0; i < 4; i++) begin
      rx_active = i[0]; rx_error = i[1];
      bus_wr(8'h0D, 8'h00);
      #1 chk("R11 urgent", {31'd0, rx_urgent}, {31'd0, i[0] | i[1]});
    end
    rx_active = 1'b0; rx_error = 1'b0;
    bus_wr(8'h0D, 8'h1F);

    // wait for ID settle
    repeat (SETTLE + 5) @(negedge clk);
    id_ok = 1'b1;

    // R5 basic rise/fall
    stat_change("R5 rise bit1", 5'b00010);
    do_clr(5'b00010);
    stat_change("R5 fall bit1", 5'b00000);
    stat_change("R5 rise bit3", 5'b01000);
    do_clr(5'b11111);

    // R6 both enables clear on bit 2
    bus_wr(8'h0F, 8'h04); bus_wr(8'h12, 8'h04);
    stat_change("R6 disabled rise", 5'b01100);
    stat_change("R6 disabled fall", 5'b01000);
    bus_wr(8'h0F, 8'h08);
    stat_change("R6 rise-only disabled", 5'b00000);
    stat_change("R6 fall enabled", 5'b01000);
    bus_wr(8'h0D, 8'h1F); bus_wr(8'h10, 8'h1F);
    do_clr(5'b11111);

    // R7 host mode
    pulldn_dm = 1'b0;
    stat_change("R7 not host", 5'b01001);
    pulldn_dm = 1'b1;
    stat_change("R7 host", 5'b01000);
    do_clr(5'b11111);

    // R8 ID settle
    id_pullup = 1'b0; @(negedge clk); id_pullup = 1'b1; id_ok = 1'b0;
    stat_change("R8 unsettled", 5'b11000);
    repeat (SETTLE) @(negedge clk); id_ok = 1'b1;
    stat_change("R8 settled", 5'b01000);
    do_clr(5'b11111);
    repeat (20) @(negedge clk);
    id_pullup = 1'b0; @(negedge clk); id_pullup = 1'b1; id_ok = 1'b0;
    repeat (20) @(negedge clk);
    stat_change("R8 restart", 5'b11000);
    repeat (SETTLE) @(negedge clk); id_ok = 1'b1;

    // R9 event wins over same-cycle clear
    stat_change("R9 setup", 5'b11010);
    stat_in = 5'b11110;
    repeat (2) @(negedge clk);
    clr_valid = 1'b1; clr_mask = 5'b00110;
    @(negedge clk);
    clr_valid = 1'b0;
    m_pend = (m_pend & ~5'b00110) | 5'b00100;
    chk("R9 event beats clear", {27'd0, evt_pending}, {27'd0, m_pend});
    @(negedge clk);
    do_clr(5'b11111);

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int it = 0; it < 300; it++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 7);
      if (sel < 6) a = 8'h0D + 8'(sel);
      else a = 8'($urandom_range(0, 255));
      bus_wr(a, 8'($urandom));
      rd_chk("R2 random rise", 8'h0D);
      rd_chk("R3 random fall", 8'h12);
      rd_chk("R4 random addr", a);
      pulldn_dp = ($urandom_range(0, 3) != 0);
      pulldn_dm = ($urandom_range(0, 3) != 0);
      stat_change("R5 random", 5'($urandom));
      if ($urandom_range(0, 2) == 0) do_clr(5'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule